// File: doc/BRIEF.md
# DDR2 Auto-Refresh Sequencer

This block keeps a DDR2 SDRAM refreshed on behalf of a memory controller. A free-running tick counter marks out the average refresh period in clock cycles; each expiry adds one owed refresh to a small debt counter. When a hot-device input is high, the period is cut in half. While refreshes are owed and the sequencer is idle, it raises a request to the controller's command arbiter. Once the arbiter grants, the sequencer owns the command bus. If any bank is open, it closes all banks with one precharge that has A10 high and waits tRP. It then issues REFRESH. If more refreshes are still owed, further REFRESH commands follow back to back, each one tRFC after the last. The bus is released tRFC after the final REFRESH.

The request/grant pair follows valid/ready rules. Once the request rises it stays high until the cycle in which grant is sampled high, and the arbiter may hold grant low for as long as it likes. The exception is a full debt counter (eight owed refreshes): the request is then flagged urgent, and the sequencer takes the bus on the next edge even without a grant. Busy stays high from the cycle after the handover until tRFC after the last REFRESH. While busy, the block drives NOP on every cycle that carries no precharge or refresh. All periods are parameters given in clock cycles, and tRP and tRFC must each be at least 2.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: After reset, req_o, urgent_o, busy_o and a10_o are low and cmd_o is NOP (4'b0111).
- R2: With hot_i low, the first request rises REF_INTERVAL cycles after reset is released, and owed refreshes then fall due every REF_INTERVAL cycles.
- R3: With hot_i high, refreshes fall due every REF_INTERVAL/2 cycles.
- R4: A request stays high until granted. On a grant with any bit of bank_open_i set, the next cycle carries PRECHARGE (4'b0010) with a10_o high.
- R5: The first REFRESH (4'b0001) follows the precharge by exactly T_RP cycles, with NOP in between.
- R6: On a grant with bank_open_i all zero, REFRESH appears on the very next cycle and no precharge is issued.
- R7: busy_o is high from the cycle after the handover until T_RFC cycles after the last REFRESH, and low otherwise. req_o is low while busy, and cmd_o is NOP whenever busy_o is low.
- R8: If N refreshes are owed at the handover, exactly N REFRESH commands are issued, spaced exactly T_RFC cycles apart.
- R9: Owed refreshes saturate at DEBT_MAX. At that count urgent_o rises with req_o, and the sequence starts on the next edge even with gnt_i low.
- R10: Commands on cmd_o are encoded as {CS#, RAS#, CAS#, WE#}: NOP = 4'b0111, PRECHARGE = 4'b0010, REFRESH = 4'b0001. No other value is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | High-temperature mode; halves the refresh period |
| bank_open_i | input | NUM_BANKS | One bit per bank that currently has a row open |
| gnt_i | input | 1 | Arbiter grant of the command bus |
| req_o | output | 1 | Request for the command bus; refresh owed |
| urgent_o | output | 1 | Request cannot be refused; debt is full |
| busy_o | output | 1 | Sequencer owns the command bus |
| cmd_o | output | 4 | {CS#, RAS#, CAS#, WE#} command |
| a10_o | output | 1 | Address bit 10; high marks an all-bank precharge |

## Verification
A period counter that is off by one shows up as a request edge one cycle early or late. The first such edge appears REF_INTERVAL cycles after reset, so the error is visible within one period. A wrong wait count in the sequencer moves a REFRESH relative to its precharge or to the previous REFRESH, and the command trace shows it within tRFC cycles of the grant. A debt counter that loses or invents refreshes changes how many REFRESH commands follow one grant, or moves the cycle at which urgent_o rises, up to eight periods after the request first appears.

// File: rtl/ddr2_ref_pkg.sv
package ddr2_ref_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } ref_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RP,
    ST_REF,
    ST_RFC
  } seq_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int REF_INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  output logic tick_o
);
  localparam int CW = $clog2(REF_INTERVAL + 1);
  localparam logic [CW-1:0] LIM_COOL = CW'(REF_INTERVAL - 1);
  localparam logic [CW-1:0] LIM_HOT  = CW'(REF_INTERVAL / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  assign last_w = hot_i ? LIM_HOT : LIM_COOL;
  // the comparison is >= so that a switch into hot mode late in a period
  // ends the period at once rather than letting the count wrap
  assign tick_o = (cnt_q >= last_w);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic issue_i,
  output logic owed_o,
  output logic full_o
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] TOP = DW'(DEBT_MAX);

  logic [DW-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt_q <= '0;
    end else begin
      unique case ({tick_i, issue_i})
        2'b10:   if (debt_q != TOP) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0)  debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign owed_o = (debt_q != '0);
  assign full_o = (debt_q == TOP);
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ddr2_ref_pkg::*;
#(
  parameter int T_RP      = 6,
  parameter int T_RFC     = 42,
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 owed_i,
  input  logic                 full_i,
  input  logic                 gnt_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 issue_o,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 busy_o,
  output logic [3:0]           cmd_o,
  output logic                 a10_o
);
  localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [WW-1:0] RP_LOAD  = WW'(T_RP - 1);
  localparam logic [WW-1:0] RFC_LOAD = WW'(T_RFC - 1);

  seq_state_e    st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          take_w;

  assign req_o    = (st_q == ST_IDLE) && owed_i;
  assign urgent_o = req_o && full_i;
  assign take_w   = req_o && (gnt_i || full_i);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    unique case (st_q)
      ST_IDLE: if (take_w) st_d = (|bank_open_i) ? ST_PRE : ST_REF;
      ST_PRE: begin
        wcnt_d = RP_LOAD;
        st_d   = ST_RP;
      end
      ST_RP: begin
        if (wcnt_q == WW'(1)) st_d = ST_REF;
        else                  wcnt_d = wcnt_q - 1'b1;
      end
      ST_REF: begin
        wcnt_d = RFC_LOAD;
        st_d   = ST_RFC;
      end
      ST_RFC: begin
        if (wcnt_q == WW'(1)) st_d = owed_i ? ST_REF : ST_IDLE;
        else                  wcnt_d = wcnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  cmd_o = CMD_PRE;
      ST_REF:  cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign issue_o = (st_q == ST_REF);
  assign busy_o  = (st_q != ST_IDLE);
  assign a10_o   = (st_q == ST_PRE);
endmodule

// File: rtl/ddr2_refresh_sched.sv
module ddr2_refresh_sched #(
  parameter int REF_INTERVAL = 3120,
  parameter int T_RP         = 6,
  parameter int T_RFC        = 42,
  parameter int DEBT_MAX     = 8,
  parameter int NUM_BANKS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hot_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 gnt_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 busy_o,
  output logic [3:0]           cmd_o,
  output logic                 a10_o
);
  logic tick_w, issue_w, owed_w, full_w;

  ref_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .tick_o(tick_w)
  );

  ref_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .issue_i(issue_w),
    .owed_o(owed_w), .full_o(full_w)
  );

  ref_seq_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .owed_i(owed_w), .full_i(full_w),
    .gnt_i(gnt_i), .bank_open_i(bank_open_i), .issue_o(issue_w),
    .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o),
    .cmd_o(cmd_o), .a10_o(a10_o)
  );
endmodule

// File: rtl/ddr2_refresh_sched_chk.sv
module ddr2_refresh_sched_chk #(
  parameter int T_RP  = 6,
  parameter int T_RFC = 42
) (
  input logic       clk,
  input logic       rst_n,
  input logic       gnt_i,
  input logic       req_o,
  input logic       urgent_o,
  input logic       busy_o,
  input logic [3:0] cmd_o,
  input logic       a10_o
);
  logic [15:0] gap_q;
  logic [1:0]  last_q;   // 0 none, 1 precharge, 2 refresh

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      last_q <= 2'd0;
    end else if (cmd_o == 4'b0010) begin
      gap_q  <= 16'd1;
      last_q <= 2'd1;
    end else if (cmd_o == 4'b0001) begin
      gap_q  <= 16'd1;
      last_q <= 2'd2;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 16'd1;
    end
  end

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'b0010) |-> a10_o); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> (req_o || busy_o)); // R4
  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'b0001 && last_q == 2'd1) |-> (gap_q >= 16'(T_RP))); // R5
  AST_RFC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'b0001 && last_q == 2'd2) |-> (gap_q >= 16'(T_RFC))); // R8
  AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> busy_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cmd_o == 4'b0111)); // R7
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_o); // R7
  AST_URGENT_SEIZE: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |=> busy_o); // R9
  AST_URGENT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> req_o); // R9
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'b0111) || (cmd_o == 4'b0010) || (cmd_o == 4'b0001)); // R10
endmodule

bind ddr2_refresh_sched ddr2_refresh_sched_chk #(.T_RP(T_RP), .T_RFC(T_RFC)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_i(gnt_i), .req_o(req_o), .urgent_o(urgent_o),
  .busy_o(busy_o), .cmd_o(cmd_o), .a10_o(a10_o)
);

// File: tb/sim_ddr2_refresh_sched.sv
`timescale 1ns/1ps
module sim_ddr2_refresh_sched;
  localparam int IVL = 80;
  localparam int TRP = 3;
  localparam int TRFC = 7;
  localparam int DMAX = 8;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot = 1'b0;
  logic [NB-1:0] banks = '0;
  logic gnt = 1'b0;
  logic req, urg, busy, a10;
  logic [3:0] cmd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  ddr2_refresh_sched #(.REF_INTERVAL(IVL), .T_RP(TRP), .T_RFC(TRFC),
                       .DEBT_MAX(DMAX), .NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .hot_i(hot), .bank_open_i(banks), .gnt_i(gnt),
    .req_o(req), .urgent_o(urg), .busy_o(busy), .cmd_o(cmd), .a10_o(a10)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_cmd(input int k, input bit any_open, input int nref);
    int first;
    first = any_open ? 1 + TRP : 1;
    if (any_open && k == 1) return 4'b0010;
    if (k >= first && ((k - first) % TRFC) == 0 && ((k - first) / TRFC) < nref)
      return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic int seq_len(input bit any_open, input int nref);
    return (any_open ? 1 + TRP : 1) + nref * TRFC;
  endfunction

  // called at a negedge with req high; checks the whole command trace
  task automatic run_seq(input bit grant, input int nref, input logic [NB-1:0] bm,
                         input string tag);
    int last;
    int ec;
    bit any;
    any = (bm != '0);
    last = seq_len(any, nref);
    banks = bm;
    gnt = grant;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      gnt = 1'b0;
      ec = exp_cmd(k, any, nref);
      chk(int'(cmd) == ec, tag, cmd, ec);                       // R10 encoding
      chk(busy == (k < last), "R7", busy, (k < last));
      chk(a10 == (ec == 4'b0010), "R4", a10, (ec == 4'b0010));
      if (k < last) chk(!req, "R7", req, 0);
    end
    banks = NB'($urandom);
  endtask

  task automatic wait_req(output int t);
    while (!req) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0, t1, d;
    logic [NB-1:0] bm;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req && !urg && !busy && !a10, "R1", {req, urg, busy, a10}, 0);
    chk(cmd == 4'b0111, "R1", cmd, 4'b0111);
    rst_n = 1'b1;

    // R2 first due time, then R6 no-bank sequence
    wait_req(t0);
    chk(t0 == IVL, "R2", t0, IVL);
    run_seq(1'b1, 1, '0, "R6");

    // R2 spacing, R5 precharge path
    wait_req(t1);
    chk(t1 - t0 == IVL, "R2", t1 - t0, IVL);
    t0 = t1;
    run_seq(1'b1, 1, 4'b0101, "R5");

    // random grant delays and bank patterns
    for (int i = 0; i < 6; i++) begin
      wait_req(t1);
      chk(t1 - t0 == IVL, "R2", t1 - t0, IVL);
      t0 = t1;
      d = int'($urandom % 11);
      for (int j = 0; j < d; j++) begin
        @(negedge clk);
        chk(req && !busy, "R4", {req, busy}, 2);
      end
      bm = NB'($urandom);
      run_seq(1'b1, 1, bm, (bm != '0) ? "R5" : "R6");
    end

    // R8 debt of three refreshes served back to back
    wait_req(t1);
    t0 = t1;
    for (int j = 0; j < 2 * IVL; j++) begin
      @(negedge clk);
      chk(req && !busy && !urg, "R8", {req, busy, urg}, 4);
    end
    run_seq(1'b1, 3, NB'($urandom), "R8");

    // R9 saturation: urgent after DMAX owed, seize without grant
    wait_req(t1);
    d = 0;
    while (!urg && d < DMAX * IVL) begin
      @(negedge clk);
      d++;
      chk(req && !busy, "R9", {req, busy}, 2);
    end
    chk(d == (DMAX - 1) * IVL, "R9", d, (DMAX - 1) * IVL);
    run_seq(1'b0, DMAX, 4'b0001, "R9");

    // R3 hot mode halves the period
    wait_req(t0);
    hot = 1'b1;
    run_seq(1'b1, 1, '0, "R3");
    for (int i = 0; i < 2; i++) begin
      wait_req(t1);
      chk(t1 - t0 == IVL / 2, "R3", t1 - t0, IVL / 2);
      t0 = t1;
      run_seq(1'b1, 1, NB'($urandom), "R3");
    end
    hot = 1'b0;
    wait_req(t1);
    t0 = t1;
    run_seq(1'b1, 1, '0, "R2");
    wait_req(t1);
    chk(t1 - t0 == IVL, "R2", t1 - t0, IVL);
    run_seq(1'b1, 1, '0, "R10");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule